// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Error Flags

This block is the receive half of an asynchronous serial port. It watches a serial input line and times each bit from a sample enable running at 16 times the bit rate. It assembles a character least significant bit first, then checks the optional parity bit and the stop bit. It also checks whether the previous character has been taken before it hands the new one to a data register. Three sticky error flags record overrun, framing and parity failures. While any of them is set, the channel stops accepting new frames until every flag has been cleared.

The controller is a single state machine with these states:

- `ST_IDLE`: waits for a low line.
- `ST_START`: confirms the start bit at its midpoint.
- `ST_DATA`: shifts in the data bits.
- `ST_PAR`: takes the parity bit.
- `ST_STOP`: judges the first stop bit and completes the frame.
- `ST_STOP2`: lets a second stop bit pass without checking it.
- `ST_HALT`: holds reception off while an error flag is set.

The transitions are:

- `ST_IDLE` to `ST_START`: the line is low on a sample enable.
- `ST_IDLE` to `ST_HALT`: an error flag is set.
- `ST_START` to `ST_DATA`: the line is still low at mid-bit.
- `ST_START` to `ST_IDLE`: the line is high at mid-bit, so the start was a glitch.
- `ST_DATA` to `ST_PAR` or `ST_STOP`: after the last data bit, depending on whether parity is enabled.
- `ST_PAR` to `ST_STOP`.
- `ST_STOP` to `ST_STOP2` or `ST_IDLE`: depending on the stop-bit count.
- `ST_STOP2` to `ST_IDLE`.
- `ST_HALT` to `ST_IDLE`: all error flags are clear.

Software reads the character from `rx_data` and acknowledges it with `rd_strobe`. It clears each flag with its own clear strobe. Two request lines, both gated by `irq_en`, report a waiting character and a pending error.

Top module: `async_rx_channel`

## Requirements
- R1: With the receiver idle, a low line on a `tick` starts a frame. The line is sampled again 8 ticks later, at mid start bit. If it is high there, the receiver returns to idle with no flag changed and stays ready for the next frame.
- R2: Data bits are sampled every 16 ticks after the start-bit midpoint. They are assembled least significant bit first, so the first data bit received lands in `rx_data[0]`.
- R3: When `par_en`=1, one parity bit follows the data. Count the 1s over the data bits and the parity bit together. A parity error occurs when that count is odd with `par_odd`=0, or even with `par_odd`=1.
- R4: The first stop bit must be 1; a 0 there is a framing error. When `two_stop`=1, the second stop bit is not checked, so a 0 there causes no error.
- R5: When a frame completes with no error while `full`=0, the character is written to `rx_data` and `full` becomes 1. `full` never rises at any other time.
- R6: When a frame completes while `full` is 1 and is not being cleared, `ovr_err` becomes 1. In that case `rx_data` and `full` are unchanged, and framing and parity are not evaluated.
- R7: When a frame without overrun has a framing or parity failure, the matching flag (`frm_err` or `par_err`) is set and the character is still written to `rx_data`. `full` stays 0 in this case.
- R8: While any error flag is 1, frames on the line are ignored. Once all flags have been cleared, reception resumes from idle.
- R9: `irq_rx` is `full` AND `irq_en`. `irq_err` is (`ovr_err` OR `frm_err` OR `par_err`) AND `irq_en`.
- R10: `rd_strobe` or `clr_full` clears `full`. `clr_ovr`, `clr_frm` and `clr_par` each clear only their own flag.
- R11: A frame that completes in the same cycle that `full` is being cleared is treated as arriving into an empty register. It is loaded, `full` ends at 1, and no overrun is flagged.
- R12: After reset, `full`, all error flags, both request lines and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line, idle high |
| tick | input | 1 | Sample enable at 16x the bit rate |
| par_en | input | 1 | 1 = a parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| irq_en | input | 1 | Enable for both request lines |
| rd_strobe | input | 1 | Data register read; clears `full` |
| clr_full | input | 1 | Clears `full` |
| clr_ovr | input | 1 | Clears `ovr_err` |
| clr_frm | input | 1 | Clears `frm_err` |
| clr_par | input | 1 | Clears `par_err` |
| rx_data | output | DATA_W | Received character |
| full | output | 1 | Character waiting |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing flag |
| par_err | output | 1 | Parity flag |
| irq_rx | output | 1 | Character-waiting request |
| irq_err | output | 1 | Error request |

## Verification
Frame completion and a software clear of `full` can land in the same cycle, and the design must let the clear win before it tests for overrun. The bench first measures, at the ports, how many cycles a frame takes from its start edge until `full` rises. It then leaves `full` set and sends a second identical frame, pulsing `rd_strobe` for exactly the one cycle of the completion edge. The result is judged by the new character in `rx_data`, `full` at 1 and `ovr_err` at 0. If the design used the stale `full` value, the result would show an overrun and the old character instead.

// File: rtl/arx_pkg.sv
package arx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } arx_state_e;

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] r;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= {STAGES{RESET_VAL}};
                end else begin
                    r[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        r[i] <= r[i-1];
                    end
                end
            end

            assign q = r[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/arx_framer.sv
module arx_framer
    import arx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_s,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              err_any,
    output logic              done,
    output logic [DATA_W-1:0] frame_data,
    output logic              frm_bad,
    output logic              par_bad
);

    localparam int CNT_W = $clog2(OVS);
    localparam int HALF  = OVS / 2;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    arx_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              acc;
    logic              at_bit, at_half;

    assign at_bit  = tick && (cnt == CNT_W'(OVS - 1));
    assign at_half = tick && (cnt == CNT_W'(HALF - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transition logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (err_any)            nxt = ST_HALT;
                else if (tick && !rxd_s) nxt = ST_START;
            end
            ST_HALT: begin
                if (!err_any) nxt = ST_IDLE;
            end
            ST_START: begin
                if (at_half) nxt = rxd_s ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (at_bit && idx == LAST_IDX) nxt = par_en ? ST_PAR : ST_STOP;
            end
            ST_PAR: begin
                if (at_bit) nxt = ST_STOP;
            end
            ST_STOP: begin
                if (at_bit) nxt = two_stop ? ST_STOP2 : ST_IDLE;
            end
            ST_STOP2: begin
                if (at_bit) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Bit timing and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            acc   <= 1'b0;
        end else begin
            if (state == ST_IDLE || state == ST_HALT) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= (at_bit || state != nxt) ? '0 : cnt + CNT_W'(1);
            end

            if (state == ST_START) begin
                idx <= '0;
                acc <= 1'b0;
            end else if (state == ST_DATA && at_bit) begin
                idx   <= idx + IDX_W'(1);
                shreg <= {rxd_s, shreg[DATA_W-1:1]};
                acc   <= acc ^ rxd_s;
            end else if (state == ST_PAR && at_bit) begin
                acc <= acc ^ rxd_s;
            end
        end
    end

    // Frame outputs
    always_comb begin
        done       = (state == ST_STOP) && at_bit;
        frame_data = shreg;
        frm_bad    = !rxd_s;
        par_bad    = par_en && (acc ^ par_odd);
    end

    // A start seen high at mid-bit is dropped as a glitch
    assert_glitch_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && at_half && rxd_s) |=> (state == ST_IDLE));

    // Newest sample enters at the top and moves toward bit 0
    assert_lsb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && at_bit) |=> (frame_data[DATA_W-1] == $past(rxd_s)));

    // No frame may begin while an error flag is pending
    assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && (state == ST_IDLE || state == ST_HALT)) |=> (state == ST_HALT));

endmodule

// File: rtl/arx_status.sv
module arx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frm_bad,
    input  logic              par_bad,
    input  logic              rd_strobe,
    input  logic              clr_full,
    input  logic              clr_ovr,
    input  logic              clr_frm,
    input  logic              clr_par,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              full,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              par_err,
    output logic              err_any,
    output logic              irq_rx,
    output logic              irq_err
);

    logic full_drop, slot_free, load, good;

    // Clears take effect before the completion test
    assign full_drop = rd_strobe || clr_full;
    assign slot_free = !full || full_drop;
    assign load      = done && slot_free;
    assign good      = load && !frm_bad && !par_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            full    <= 1'b0;
            ovr_err <= 1'b0;
            frm_err <= 1'b0;
            par_err <= 1'b0;
        end else begin
            if (load) rx_data <= frame_data;

            if (good)           full <= 1'b1;
            else if (full_drop) full <= 1'b0;

            if (done && !slot_free) ovr_err <= 1'b1;
            else if (clr_ovr)       ovr_err <= 1'b0;

            if (load && frm_bad) frm_err <= 1'b1;
            else if (clr_frm)    frm_err <= 1'b0;

            if (load && par_bad) par_err <= 1'b1;
            else if (clr_par)    par_err <= 1'b0;
        end
    end

    always_comb begin
        err_any = ovr_err || frm_err || par_err;
        irq_rx  = full && irq_en;
        irq_err = err_any && irq_en;
    end

    assert_full_from_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(done));

    assert_overrun_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !rd_strobe && !clr_full) |=> (ovr_err && full && rx_data == $past(rx_data)));

    assert_error_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && slot_free && (frm_bad || par_bad)) |=> !full);

    assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !clr_ovr) |=> ovr_err);

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && rd_strobe) |=> (!ovr_err && rx_data == $past(frame_data)));

endmodule

// File: rtl/async_rx_channel.sv
module async_rx_channel #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              irq_en,
    input  logic              rd_strobe,
    input  logic              clr_full,
    input  logic              clr_ovr,
    input  logic              clr_frm,
    input  logic              clr_par,
    output logic [DATA_W-1:0] rx_data,
    output logic              full,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              par_err,
    output logic              irq_rx,
    output logic              irq_err
);

    logic              rxd_s;
    logic              done, frm_bad, par_bad, err_any;
    logic [DATA_W-1:0] frame_data;

    arx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rxd_s)
    );

    arx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd_s      (rxd_s),
        .tick       (tick),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .two_stop   (two_stop),
        .err_any    (err_any),
        .done       (done),
        .frame_data (frame_data),
        .frm_bad    (frm_bad),
        .par_bad    (par_bad)
    );

    arx_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .frame_data (frame_data),
        .frm_bad    (frm_bad),
        .par_bad    (par_bad),
        .rd_strobe  (rd_strobe),
        .clr_full   (clr_full),
        .clr_ovr    (clr_ovr),
        .clr_frm    (clr_frm),
        .clr_par    (clr_par),
        .irq_en     (irq_en),
        .rx_data    (rx_data),
        .full       (full),
        .ovr_err    (ovr_err),
        .frm_err    (frm_err),
        .par_err    (par_err),
        .err_any    (err_any),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err)
    );

endmodule

// File: tb/tb_async_rx_channel.sv
module tb_async_rx_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, irq_en = 1'b1;
    logic       rd_strobe = 1'b0, clr_full = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0, clr_par = 1'b0;
    logic [7:0] rx_data;
    logic       full, ovr_err, frm_err, par_err, irq_rx, irq_err;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  t_start = 0;
    int  n_cal = 0;
    bit  started = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    async_rx_channel dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .irq_en(irq_en),
        .rd_strobe(rd_strobe), .clr_full(clr_full), .clr_ovr(clr_ovr),
        .clr_frm(clr_frm), .clr_par(clr_par),
        .rx_data(rx_data), .full(full), .ovr_err(ovr_err), .frm_err(frm_err),
        .par_err(par_err), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    // Fields: data[15:8] pe odd two badpar stop1 stop2 exp_frm exp_par
    localparam logic [15:0] VEC [0:7] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h7E, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h0F, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    initial begin
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        rxd = b;
        repeat (32) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pe, input logic odd,
                              input logic two, input logic badpar,
                              input logic s1, input logic s2);
        logic p;
        par_en = pe; par_odd = odd; two_stop = two;
        @(negedge clk);
        while (cyc[0]) @(negedge clk);
        t_start = cyc;
        started = 1'b1;
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(d[i]);
        p = (odd ? ~^d : ^d) ^ badpar;
        if (pe) bit_out(p);
        bit_out(s1);
        if (two) bit_out(s2);
        rxd = 1'b1;
        started = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic pulse(input bit r, input bit cf, input bit co, input bit cfr, input bit cp);
        @(negedge clk);
        rd_strobe = r; clr_full = cf; clr_ovr = co; clr_frm = cfr; clr_par = cp;
        @(negedge clk);
        rd_strobe = 0; clr_full = 0; clr_ovr = 0; clr_frm = 0; clr_par = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (10) @(negedge clk);
        // R12 reset state
        chk("R12 full", full, 0);
        chk("R12 errors", {ovr_err, frm_err, par_err}, 0);
        chk("R12 irqs", {irq_rx, irq_err}, 0);
        chk("R12 data", rx_data, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table of frames: R2 R3 R4 R5 R7 R9
        irq_en = 1'b1;
        for (int v = 0; v < 8; v++) begin
            logic [15:0] e;
            logic        ef, ep;
            e  = VEC[v];
            ef = e[1];
            ep = e[0];
            send_frame(e[15:8], e[7], e[6], e[5], e[4], e[3], e[2]);
            chk($sformatf("R2 R7 data v%0d", v), rx_data, e[15:8]);
            chk($sformatf("R5 R7 full v%0d", v), full, !(ef || ep));
            chk($sformatf("R4 frm v%0d", v), frm_err, ef);
            chk($sformatf("R3 par v%0d", v), par_err, ep);
            chk($sformatf("R9 irqs v%0d", v), {irq_rx, irq_err}, {!(ef || ep), (ef || ep)});
            pulse(1, 1, 1, 1, 1);
        end

        // R1 glitch on the line: low for 4 ticks only
        @(negedge clk);
        while (cyc[0]) @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (600) @(negedge clk);
        chk("R1 glitch full", full, 0);
        chk("R1 glitch flags", {ovr_err, frm_err, par_err}, 0);
        send_frame(8'h3A, 0, 0, 0, 0, 1, 1);
        chk("R1 resync data", rx_data, 8'h3A);
        chk("R1 resync full", full, 1);

        // R9 gating
        irq_en = 1'b0;
        @(negedge clk);
        chk("R9 irq_rx gated", irq_rx, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R9 irq_rx", irq_rx, 1);

        // R6 overrun
        send_frame(8'hB2, 0, 0, 0, 0, 0, 1);
        chk("R6 ovr", ovr_err, 1);
        chk("R6 data kept", rx_data, 8'h3A);
        chk("R6 full kept", full, 1);
        chk("R6 no frm", frm_err, 0);
        chk("R9 irq_err", irq_err, 1);

        // R10 selective clears
        pulse(0, 0, 0, 1, 1);
        chk("R10 ovr survives", ovr_err, 1);
        pulse(1, 0, 0, 0, 0);
        chk("R10 read clears full", full, 0);
        chk("R10 ovr after read", ovr_err, 1);

        // R8 halted while flagged, resumes after clear
        send_frame(8'h5A, 0, 0, 0, 0, 1, 1);
        chk("R8 halted full", full, 0);
        chk("R8 halted data", rx_data, 8'h3A);
        pulse(0, 0, 1, 0, 0);
        chk("R10 clr_ovr", ovr_err, 0);
        send_frame(8'h5A, 0, 0, 0, 0, 1, 1);
        chk("R8 resumed data", rx_data, 8'h5A);
        chk("R8 resumed full", full, 1);

        // R11 calibration of completion cycle, then clear on that cycle
        pulse(1, 1, 1, 1, 1);
        fork
            send_frame(8'h96, 0, 0, 0, 0, 1, 1);
            begin
                wait (started);
                @(negedge clk);
                while (!full) @(negedge clk);
                n_cal = cyc - t_start;
            end
        join
        chk("R1 mid-bit timing", (n_cal >= 300 && n_cal <= 316), 1);
        chk("R11 calib data", rx_data, 8'h96);
        fork
            send_frame(8'h69, 0, 0, 0, 0, 1, 1);
            begin
                wait (started);
                while (cyc != t_start + n_cal - 1) @(negedge clk);
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end
        join
        chk("R11 data loaded", rx_data, 8'h69);
        chk("R11 full", full, 1);
        chk("R11 no overrun", ovr_err, 0);

        finish_run();
    end

endmodule